// File: doc/BRIEF.md
# Nonvolatile Save Script Sequencer

This block copies chosen parts of a byte-wide register map into an external nonvolatile memory. It does this by running a short instruction script kept in a scratch-pad window of that same map. When software sets the save control bit, the sequencer reads the script one byte at a time through a synchronous register-read port. It stores each instruction byte in the memory, and for every data instruction it also copies the addressed register bytes. A data record ends with a checksum byte. Every byte goes out as an address/data pair on a valid/ready write channel toward the memory's serial controller.

Each run starts at memory address zero. The memory address rises by one for every byte the controller accepts, so each instruction moves the pointer by its own amount. A data instruction of value N takes 3 + N + 2 bytes; a single-byte instruction takes 1. The write-enable bit acts as write protection. A guard timer enforces a quiet gap after each transfer. The half-rate bit is passed through to the serial controller as its rate select.

Top module: `nvsave_sequencer`

## Requirements
- R1: After reset, `save_bit`, `busy`, `seq_err`, `rd_en` and `ee_valid` are all 0.
- R2: A one-cycle `save_req` sets `save_bit`. The run starts, `busy` is high while it lasts, and `save_bit` clears itself in the cycle the run ends.
- R3: A script byte with bit 7 clear (0x00–0x7F, value N) is a data instruction. The sequencer writes that byte, then the next two script bytes (source address, most significant first), then the N+1 map bytes starting at the source address, in ascending address order.
- R4: Right after the data bytes of a record, one checksum byte is written. It equals the two's-complement negation of the 8-bit sum of the two address bytes and the data bytes, so all of those bytes plus the checksum sum to 0 modulo 256.
- R5: Script bytes 0x80 (I/O update) and 0xA0 (calibrate) are each written alone as one byte, and the script continues with the following byte.
- R6: Script byte 0xFF is written and then ends the run with `seq_err` low.
- R7: Any other script byte (0x81–0x9F, 0xA1–0xFE) is not written; it ends the run and sets `seq_err`. Reading SCRIPT_LEN script bytes without meeting 0xFF also ends the run with `seq_err` set. `seq_err` stays set until the next run starts.
- R8: The memory address of the first write in a run is 0, and each accepted write raises the address of the next write by exactly 1.
- R9: While `ee_valid` is high and `ee_ready` is low, `ee_valid`, `ee_addr` and `ee_data` hold their values.
- R10: If `wr_enable` is 0 when a run would start, no write is issued, `save_bit` clears, and `seq_err` stays 0.
- R11: A save requested within HOLDOFF_CYC cycles after the previous run ended is held pending with `save_bit` high. It starts only once that gap has elapsed.
- R12: `rate_sel` always equals `half_rate` (0 = normal rate, 1 = half rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| save_req | input | 1 | One-cycle write of 1 to the save control bit |
| wr_enable | input | 1 | Memory write enable; 0 means write protected |
| half_rate | input | 1 | Serial rate choice from the control register |
| save_bit | output | 1 | Save control bit, cleared by hardware when the run ends |
| busy | output | 1 | A script run is in progress |
| seq_err | output | 1 | Last run met an unknown instruction or no end marker |
| rate_sel | output | 1 | Rate select toward the serial controller |
| rd_en | output | 1 | Register-map read strobe |
| rd_addr | output | MAP_AW | Register-map read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| ee_valid | output | 1 | Write byte offered |
| ee_ready | input | 1 | Serial controller accepts the byte |
| ee_addr | output | EE_AW | Memory address of the byte |
| ee_data | output | 8 | Byte to be written |

## Verification
The default-style script mixes a nine-byte data record with the two single-byte instructions and the end marker. It exposes errors in pointer steps, address byte order and the checksum. A second script has two short records, one of them a single byte, and runs under a pseudo-random ready pattern. It separates a correct length count (N+1) and stable handshakes from off-by-one or stall bugs. An unknown opcode, a script with no end marker, a protected save and a save requested inside the guard gap each stop the run in a different way. Each is judged by the written byte count and the status bits.

// File: rtl/nvsave_pkg.sv
// Shared types for the save script sequencer.
// Assumes one instruction byte per script location, with opcodes decoded as below.
package nvsave_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPT,
        ST_WRITE
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_AHI,
        PH_ALO,
        PH_DATA,
        PH_CSUM
    } seq_phase_e;

    typedef enum logic [1:0] {
        OPK_DATA,
        OPK_SINGLE,
        OPK_END,
        OPK_BAD
    } op_kind_e;

    localparam logic [7:0] OPC_IOUPD = 8'h80;
    localparam logic [7:0] OPC_CALIB = 8'hA0;
    localparam logic [7:0] OPC_END   = 8'hFF;

    // Classify one script byte into its instruction kind.
    function automatic op_kind_e op_classify(input logic [7:0] b);
        if (!b[7])                               return OPK_DATA;
        else if (b == OPC_IOUPD || b == OPC_CALIB) return OPK_SINGLE;
        else if (b == OPC_END)                   return OPK_END;
        else                                     return OPK_BAD;
    endfunction

endpackage

// File: rtl/nvsave_holdoff.sv
// Guard timer: after each transfer ends, holds ready low for HOLDOFF_CYC cycles.
// Assumes start_i is a single-cycle pulse at the end of a transfer.
module nvsave_holdoff #(
    parameter int HOLDOFF_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o
);
    localparam int CW = $clog2(HOLDOFF_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Load on transfer end, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start_i)      cnt_q <= CW'(HOLDOFF_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/nvsave_cksum.sv
// Running checksum of one data record: the negated 8-bit sum of added bytes.
// Assumes clr_i and add_i never coincide.
module nvsave_cksum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       add_i,
    input  logic [7:0] byte_i,
    output logic [7:0] cksum_o
);
    logic [7:0] sum_q;

    // Accumulate address and data bytes modulo 256.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (clr_i)  sum_q <= '0;
        else if (add_i)  sum_q <= sum_q + byte_i;
    end

    assign cksum_o = (~sum_q) + 8'd1;
endmodule

// File: rtl/nvsave_walker.sv
// Script walker: fetches script bytes, decodes instructions, copies map bytes and
// emits every byte with its memory address on a valid/ready channel.
// Assumes the read port returns data one cycle after rd_en and map addresses fit MAP_AW.
module nvsave_walker
    import nvsave_pkg::*;
#(
    parameter int MAP_AW      = 16,
    parameter int EE_AW       = 16,
    parameter int SCRIPT_BASE = 'h0E10,
    parameter int SCRIPT_LEN  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              wp_ok_i,
    output logic              start_o,
    output logic              finish_o,
    output logic              err_set_o,
    output logic              busy_o,
    output logic              rd_en_o,
    output logic [MAP_AW-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              ee_valid_o,
    input  logic              ee_ready_i,
    output logic [EE_AW-1:0]  ee_addr_o,
    output logic [7:0]        ee_data_o,
    output logic              ck_clr_o,
    output logic              ck_add_o,
    output logic [7:0]        ck_byte_o,
    input  logic [7:0]        ck_val_i
);
    localparam int SP_W = $clog2(SCRIPT_LEN + 1);

    seq_state_e       st_q;
    seq_phase_e       ph_q;
    logic [SP_W-1:0]  sp_q;
    logic [7:0]       src_hi_q;
    logic [7:0]       src_lo_q;
    logic [6:0]       len_q;
    logic [6:0]       cnt_q;
    logic [7:0]       byte_q;
    logic [EE_AW-1:0] ptr_q;
    logic             accept;
    logic [MAP_AW-1:0] src_addr;

    assign accept   = (st_q == ST_WRITE) && ee_ready_i;
    assign src_addr = MAP_AW'({src_hi_q, src_lo_q}) + MAP_AW'(cnt_q);

    // Decide run start, run end and error events for this cycle.
    always_comb begin
        start_o   = 1'b0;
        finish_o  = 1'b0;
        err_set_o = 1'b0;
        case (st_q)
            ST_IDLE: begin
                start_o  = go_i;
                finish_o = go_i && !wp_ok_i;
            end
            ST_READ: begin
                if (ph_q == PH_OPC && sp_q == SP_W'(SCRIPT_LEN)) begin
                    finish_o  = 1'b1;
                    err_set_o = 1'b1;
                end
            end
            ST_CAPT: begin
                if (ph_q == PH_OPC && op_classify(rd_data_i) == OPK_BAD) begin
                    finish_o  = 1'b1;
                    err_set_o = 1'b1;
                end
            end
            ST_WRITE: begin
                finish_o = accept && ph_q == PH_OPC && byte_q == OPC_END;
            end
            default: ;
        endcase
    end

    // Sequence through fetch, capture and write for each script or map byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            ph_q     <= PH_OPC;
            sp_q     <= '0;
            src_hi_q <= '0;
            src_lo_q <= '0;
            len_q    <= '0;
            cnt_q    <= '0;
            byte_q   <= '0;
            ptr_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (go_i && wp_ok_i) begin
                        st_q  <= ST_READ;
                        ph_q  <= PH_OPC;
                        sp_q  <= '0;
                        ptr_q <= '0;
                    end
                end
                ST_READ: begin
                    st_q <= finish_o ? ST_IDLE : ST_CAPT;
                end
                ST_CAPT: begin
                    byte_q <= rd_data_i;
                    st_q   <= finish_o ? ST_IDLE : ST_WRITE;
                end
                ST_WRITE: begin
                    if (ee_ready_i) begin
                        ptr_q <= ptr_q + 1'b1;
                        case (ph_q)
                            PH_OPC: begin
                                sp_q <= sp_q + 1'b1;
                                if (finish_o) begin
                                    st_q <= ST_IDLE;
                                end else if (op_classify(byte_q) == OPK_DATA) begin
                                    len_q <= byte_q[6:0];
                                    ph_q  <= PH_AHI;
                                    st_q  <= ST_READ;
                                end else begin
                                    st_q <= ST_READ;
                                end
                            end
                            PH_AHI: begin
                                src_hi_q <= byte_q;
                                sp_q     <= sp_q + 1'b1;
                                ph_q     <= PH_ALO;
                                st_q     <= ST_READ;
                            end
                            PH_ALO: begin
                                src_lo_q <= byte_q;
                                sp_q     <= sp_q + 1'b1;
                                cnt_q    <= '0;
                                ph_q     <= PH_DATA;
                                st_q     <= ST_READ;
                            end
                            PH_DATA: begin
                                if (cnt_q == len_q) begin
                                    ph_q <= PH_CSUM;
                                end else begin
                                    cnt_q <= cnt_q + 1'b1;
                                    st_q  <= ST_READ;
                                end
                            end
                            default: begin
                                ph_q <= PH_OPC;
                                st_q <= ST_READ;
                            end
                        endcase
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o     = (st_q != ST_IDLE);
    assign rd_en_o    = (st_q == ST_READ) && !finish_o;
    assign rd_addr_o  = (ph_q == PH_DATA) ? src_addr
                                          : MAP_AW'(SCRIPT_BASE) + MAP_AW'(sp_q);
    assign ee_valid_o = (st_q == ST_WRITE);
    assign ee_addr_o  = ptr_q;
    assign ee_data_o  = (ph_q == PH_CSUM) ? ck_val_i : byte_q;
    assign ck_clr_o   = accept && (ph_q == PH_OPC);
    assign ck_add_o   = accept && (ph_q == PH_AHI || ph_q == PH_ALO || ph_q == PH_DATA);
    assign ck_byte_o  = byte_q;
endmodule

// File: rtl/nvsave_sequencer.sv
// Top of the save script sequencer: control bits, guard timer, checksum and walker.
// Assumes save_req is a single-cycle strobe from the register write decoder.
module nvsave_sequencer #(
    parameter int MAP_AW      = 16,
    parameter int EE_AW       = 16,
    parameter int SCRIPT_BASE = 'h0E10,
    parameter int SCRIPT_LEN  = 48,
    parameter int HOLDOFF_CYC = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_req,
    input  logic              wr_enable,
    input  logic              half_rate,
    output logic              save_bit,
    output logic              busy,
    output logic              seq_err,
    output logic              rate_sel,
    output logic              rd_en,
    output logic [MAP_AW-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              ee_valid,
    input  logic              ee_ready,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_data
);
    logic       hold_ready;
    logic       run_start;
    logic       run_finish;
    logic       err_set;
    logic       ck_clr;
    logic       ck_add;
    logic [7:0] ck_byte;
    logic [7:0] ck_val;

    // Self-clearing save control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          save_bit <= 1'b0;
        else if (run_finish) save_bit <= 1'b0;
        else if (save_req)   save_bit <= 1'b1;
    end

    // Sticky error flag, cleared when a new run starts.
    always_ff @(posedge clk) begin
        if (!rst_n)         seq_err <= 1'b0;
        else if (err_set)   seq_err <= 1'b1;
        else if (run_start) seq_err <= 1'b0;
    end

    assign rate_sel = half_rate;

    nvsave_holdoff #(
        .HOLDOFF_CYC(HOLDOFF_CYC)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(run_finish),
        .ready_o(hold_ready)
    );

    nvsave_cksum u_cksum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ck_clr),
        .add_i  (ck_add),
        .byte_i (ck_byte),
        .cksum_o(ck_val)
    );

    nvsave_walker #(
        .MAP_AW     (MAP_AW),
        .EE_AW      (EE_AW),
        .SCRIPT_BASE(SCRIPT_BASE),
        .SCRIPT_LEN (SCRIPT_LEN)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (save_bit && hold_ready),
        .wp_ok_i   (wr_enable),
        .start_o   (run_start),
        .finish_o  (run_finish),
        .err_set_o (err_set),
        .busy_o    (busy),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .ee_valid_o(ee_valid),
        .ee_ready_i(ee_ready),
        .ee_addr_o (ee_addr),
        .ee_data_o (ee_data),
        .ck_clr_o  (ck_clr),
        .ck_add_o  (ck_add),
        .ck_byte_o (ck_byte),
        .ck_val_i  (ck_val)
    );
endmodule

// File: rtl/nvsave_checker.sv
// Protocol checker for the save script sequencer, bound to the top module.
// Assumes it sees the top-level ports only.
module nvsave_checker #(
    parameter int EE_AW       = 16,
    parameter int HOLDOFF_CYC = 2500
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             save_bit,
    input logic             wr_enable,
    input logic             rd_en,
    input logic             ee_valid,
    input logic             ee_ready,
    input logic [EE_AW-1:0] ee_addr,
    input logic [7:0]       ee_data
);
    int   gap_q;
    logic armed_q;

    // Count cycles since the last run ended, saturating past the guard gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= 0;
            armed_q <= 1'b0;
        end else if ($fell(busy)) begin
            gap_q   <= 1;
            armed_q <= 1'b1;
        end else if (gap_q <= HOLDOFF_CYC) begin
            gap_q <= gap_q + 1;
        end
    end

    assert_busy_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> save_bit);

    assert_read_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_valid && ee_ready) |=> (!ee_valid || ee_addr == $past(ee_addr) + 1'b1));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_valid && !ee_ready) |=> (ee_valid && $stable(ee_addr) && $stable(ee_data)));

    assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_enable));

    assert_guard_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && armed_q) |-> (gap_q >= HOLDOFF_CYC));
endmodule

bind nvsave_sequencer nvsave_checker #(
    .EE_AW      (EE_AW),
    .HOLDOFF_CYC(HOLDOFF_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .save_bit (save_bit),
    .wr_enable(wr_enable),
    .rd_en    (rd_en),
    .ee_valid (ee_valid),
    .ee_ready (ee_ready),
    .ee_addr  (ee_addr),
    .ee_data  (ee_data)
);

// File: tb/nvsave_sequencer_tb.sv
// Directed bench for the save script sequencer.
module nvsave_sequencer_tb;
    localparam int HOLD = 2500;
    localparam int SLEN = 48;
    localparam int BASE = 'h0E10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        save_req = 1'b0;
    logic        wr_enable = 1'b1;
    logic        half_rate = 1'b0;
    logic        save_bit, busy, seq_err, rate_sel, rd_en, ee_valid;
    logic [15:0] rd_addr, ee_addr;
    logic [7:0]  rd_data = 8'h00;
    logic        ee_ready = 1'b1;
    logic [7:0]  ee_data;

    int checks = 0;
    int errors = 0;
    bit bp_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [7:0] mem [0:4095];
    logic [7:0] sc [0:SLEN-1];
    logic [7:0] got_d [0:255];
    logic [15:0] got_a [0:255];
    int got_n = 0;
    logic [7:0] exp_d [0:255];
    int exp_n;
    bit exp_err;

    always #2 clk = ~clk;

    nvsave_sequencer #(.HOLDOFF_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .wr_enable(wr_enable),
        .half_rate(half_rate), .save_bit(save_bit), .busy(busy), .seq_err(seq_err),
        .rate_sel(rate_sel), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ee_valid(ee_valid), .ee_ready(ee_ready), .ee_addr(ee_addr), .ee_data(ee_data)
    );

    function automatic logic [7:0] mapb(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction

    // Synchronous register-map model.
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[11:0]];

    // Ready pattern and write capture, away from the active edge.
    always @(negedge clk) begin
        ee_ready = bp_mode ? lfsr[0] : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (ee_valid && ee_ready && got_n < 256) begin
            got_d[got_n] = ee_data;
            got_a[got_n] = ee_addr;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_script(input logic [7:0] fillv);
        for (int i = 0; i < SLEN; i++) sc[i] = fillv;
    endtask

    // Copy the script into the map and build the expected byte stream.
    task automatic commit_script();
        int i;
        bit stop;
        logic [7:0] sum;
        for (int k = 0; k < 4096; k++) mem[k] = mapb(12'(k));
        for (int k = 0; k < SLEN; k++) mem[BASE + k] = sc[k];
        exp_n = 0; exp_err = 1'b0; i = 0; stop = 1'b0;
        while (!stop) begin
            if (i >= SLEN) begin exp_err = 1'b1; stop = 1'b1; end
            else if (!sc[i][7]) begin
                exp_d[exp_n++] = sc[i];
                exp_d[exp_n++] = sc[i+1];
                exp_d[exp_n++] = sc[i+2];
                sum = sc[i+1] + sc[i+2];
                for (int k = 0; k <= int'(sc[i]); k++) begin
                    exp_d[exp_n] = mapb(12'({sc[i+1], sc[i+2]} + 16'(k)));
                    sum = sum + exp_d[exp_n];
                    exp_n++;
                end
                exp_d[exp_n++] = 8'(0 - sum);
                i += 3;
            end else if (sc[i] == 8'h80 || sc[i] == 8'hA0) begin
                exp_d[exp_n++] = sc[i];
                i++;
            end else if (sc[i] == 8'hFF) begin
                exp_d[exp_n++] = sc[i];
                stop = 1'b1;
            end else begin
                exp_err = 1'b1; stop = 1'b1;
            end
        end
    endtask

    // Pulse save and wait until the save bit clears.
    task automatic run_save(input string req);
        int t;
        got_n = 0;
        @(negedge clk) save_req = 1'b1;
        @(negedge clk) save_req = 1'b0;
        chk(save_bit == 1'b1, "R2 save bit set", save_bit, 1);
        t = 0;
        while (save_bit && t < 20000) begin @(negedge clk); t++; end
        chk(t < 20000, {req, " run ended"}, t, 0);
    endtask

    task automatic compare_stream(input string req);
        int bad;
        bad = -1;
        chk(got_n == exp_n, {req, " write count"}, got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++)
            if (bad < 0 && (got_d[k] !== exp_d[k] || got_a[k] !== 16'(k))) bad = k;
        chk(bad < 0, {req, " byte stream (R3 R4 R8 data/addr)"},
            bad < 0 ? 0 : int'(got_d[bad]), bad < 0 ? 0 : int'(exp_d[bad]));
        chk(seq_err == exp_err, {req, " error flag"}, seq_err, exp_err);
    endtask

    task automatic settle();
        repeat (HOLD + 20) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!save_bit && !busy && !seq_err && !rd_en && !ee_valid, "R1 reset state",
            {save_bit, busy, seq_err, rd_en, ee_valid}, 0);
    endtask

    task automatic t_default();
        fill_script(8'h91);
        sc[0] = 8'h08; sc[1] = 8'h01; sc[2] = 8'h00;
        sc[3] = 8'h80; sc[4] = 8'hA0; sc[5] = 8'hFF;
        commit_script();
        run_save("R3");
        compare_stream("R3 R4 R5 R6 default script");
        chk(got_n == 16 && got_d[13] == 8'h80 && got_d[14] == 8'hA0,
            "R5 single-byte instructions", got_n, 16);
        chk(got_d[15] == 8'hFF && !seq_err, "R6 end marker", got_d[15], 8'hFF);
        chk(!busy && !save_bit, "R2 autoclear", {busy, save_bit}, 0);
        settle();
    endtask

    task automatic t_backpressure();
        fill_script(8'h91);
        sc[0] = 8'h02; sc[1] = 8'h02; sc[2] = 8'h10;
        sc[3] = 8'h00; sc[4] = 8'h01; sc[5] = 8'hFE;
        sc[6] = 8'hA0; sc[7] = 8'h80; sc[8] = 8'hFF;
        commit_script();
        bp_mode = 1'b1;
        run_save("R9");
        bp_mode = 1'b0;
        compare_stream("R9 R4 backpressure two records");
        settle();
    endtask

    task automatic t_protect();
        fill_script(8'h91);
        sc[0] = 8'h80; sc[1] = 8'hFF;
        commit_script();
        wr_enable = 1'b0;
        run_save("R10");
        chk(got_n == 0, "R10 no writes when protected", got_n, 0);
        chk(!save_bit && !seq_err, "R10 bit cleared, no error", {save_bit, seq_err}, 0);
        wr_enable = 1'b1;
        settle();
    endtask

    task automatic t_badop();
        fill_script(8'h91);
        sc[0] = 8'h80; sc[1] = 8'h90; sc[2] = 8'hFF;
        commit_script();
        run_save("R7");
        compare_stream("R7 unknown opcode");
        chk(got_n == 1 && seq_err, "R7 stop on unknown", got_n, 1);
        settle();
        fill_script(8'h91);
        sc[0] = 8'hFF;
        commit_script();
        run_save("R7");
        chk(!seq_err && got_n == 1, "R7 error cleared by next run", seq_err, 0);
        settle();
    endtask

    task automatic t_noend();
        fill_script(8'hA0);
        commit_script();
        run_save("R7");
        compare_stream("R7 missing end marker");
        chk(got_n == SLEN && seq_err, "R7 script exhausted", got_n, SLEN);
        settle();
    endtask

    task automatic t_holdoff();
        int t;
        fill_script(8'h91);
        sc[0] = 8'hFF;
        commit_script();
        run_save("R11");
        @(negedge clk) save_req = 1'b1;
        @(negedge clk) save_req = 1'b0;
        repeat (HOLD - 20) @(negedge clk);
        chk(!busy && save_bit, "R11 request pending in guard gap", {busy, save_bit}, 1);
        t = 0;
        while (!busy && t < 60) begin @(negedge clk); t++; end
        chk(busy == 1'b1, "R11 deferred run starts", busy, 1);
        t = 0;
        while (save_bit && t < 1000) begin @(negedge clk); t++; end
        chk(!save_bit && got_n >= 1, "R11 deferred run completes", save_bit, 0);
        settle();
    endtask

    task automatic t_rate();
        half_rate = 1'b1;
        @(negedge clk);
        chk(rate_sel == 1'b1, "R12 half rate", rate_sel, 1);
        half_rate = 1'b0;
        @(negedge clk);
        chk(rate_sel == 1'b0, "R12 normal rate", rate_sel, 0);
    endtask

    initial begin
        for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default();
        t_backpressure();
        t_protect();
        t_badop();
        t_noend();
        t_holdoff();
        t_rate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #700000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule